// File: doc/BRIEF.md
# Triggered ADC Readout Sequencer

This block sequences the readout of one front-end event in a detector controller. While idle it watches four trigger inputs: a pulse-per-second tick, an external trigger, a front-end trigger and an internal trigger. When one fires, it records which source won and asks the time-stamp unit for the matching stamp through a request/acknowledge handshake. It then writes that stamp into an external FIFO as the first word of the event. A pulse-per-second event also sends a one-cycle increment to the external cycle counter.

Next the sequencer freezes the analog samples with a hold line and starts the converter with a request. It waits for the converter's done flag, then walks a channel index upward from 0 to the last channel. Each sample is compared against a configurable threshold, and only samples above it are kept. A kept sample produces a channel/cycle word followed by a data word. The event closes with an end marker that carries the trigger source. A full FIFO freezes the sequencer in place, and no data is lost.

Every word is 16 bits. Bits [15:13] hold a type tag and bits [12:0] hold the payload.

Top module: `trig_readout_seq`

## Requirements
- R1: After reset, `fifo_wr`, `ts_req`, `adc_hold`, `adc_req` and `cyc_incr` are all low.
- R2: When several triggers are present together while idle, the winner is chosen in this order: pulse-per-second, then external, then front-end, then internal. `ts_req` is one-hot: bit 0 asks for the PPS/cycle stamp, bit 1 for the external stamp, and bit 2 for the front-end stamp. The front-end and internal triggers both use bit 2.
- R3: `cyc_incr` pulses high for exactly one cycle for each accepted pulse-per-second event, and never for any other source.
- R4: `ts_req` holds steady until `ts_ack`. The value on `ts_val` in the acknowledge cycle becomes the first word of the event, with tag 3'b001.
- R5: After the stamp word is written, `adc_hold` and `adc_req` rise together. `adc_req` stays high until `adc_done`. `adc_hold` stays high through the whole channel scan and is low when the end marker is written.
- R6: `adc_sel` steps through channels 0 to NCH-1 in ascending order, once per event.
- R7: A sample strictly greater than `zs_thr` yields two words, in this order. The first is tag 3'b010 with payload {channel[5:0], cycle_num[6:0]}. The second is tag 3'b011 with payload {1'b0, sample[11:0]}. A sample equal to or below the threshold yields no word.
- R8: After the last channel, an end marker is written with tag 3'b111 and payload {11'b0, source}. The source code is 0 for PPS, 1 for external, 2 for front-end and 3 for internal.
- R9: `fifo_wr` is never high while `fifo_full` is high. A full FIFO stalls the sequencer without dropping, repeating or reordering any word.
- R10: Triggers that arrive while an event is in progress are ignored. Only one event is in flight at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_pps | input | 1 | Pulse-per-second trigger |
| trig_ext | input | 1 | External trigger |
| trig_fe | input | 1 | Front-end trigger |
| trig_int | input | 1 | Internal trigger |
| cyc_num | input | 13-log2(NCH) | Current cycle number from the external counter |
| cyc_incr | output | 1 | One-cycle increment request to the cycle counter |
| ts_req | output | 3 | One-hot time-stamp load request |
| ts_ack | input | 1 | Time stamp is valid on `ts_val` |
| ts_val | input | 13 | Time-stamp value |
| adc_hold | output | 1 | Sample-and-hold control |
| adc_req | output | 1 | Conversion request |
| adc_done | input | 1 | Conversion complete |
| adc_sel | output | log2(NCH) | Channel being read |
| adc_data | input | ADC_W | Sample of the selected channel |
| zs_thr | input | ADC_W | Zero-suppression threshold |
| fifo_wr | output | 1 | FIFO write enable |
| fifo_din | output | 16 | Tagged word to the FIFO |
| fifo_full | input | 1 | FIFO full flag |

## Verification
The bench builds the block with its defaults, NCH = 64 and ADC_W = 12, so the scan runs all the way to channel 63. This exercises the full 6-bit channel field and the 7-bit cycle field in every channel/cycle word. Thresholds of 0, 4095 and a value equal to one channel's sample bring in the all-pass and all-drop cases and the strict-greater boundary. Pseudo-random full-flag stalls and a stray trigger during the scan test stall safety and single-event operation.

// File: rtl/trig_readout_seq.sv
module trig_readout_seq #(
  parameter int NCH   = 64,
  parameter int ADC_W = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         trig_pps,
  input  logic                         trig_ext,
  input  logic                         trig_fe,
  input  logic                         trig_int,
  input  logic [13-$clog2(NCH)-1:0]    cyc_num,
  output logic                         cyc_incr,
  output logic [2:0]                   ts_req,
  input  logic                         ts_ack,
  input  logic [12:0]                  ts_val,
  output logic                         adc_hold,
  output logic                         adc_req,
  input  logic                         adc_done,
  output logic [$clog2(NCH)-1:0]       adc_sel,
  input  logic [ADC_W-1:0]             adc_data,
  input  logic [ADC_W-1:0]             zs_thr,
  output logic                         fifo_wr,
  output logic [15:0]                  fifo_din,
  input  logic                         fifo_full
);
  localparam int CW = $clog2(NCH);
  localparam int PW = 13;

  typedef enum logic [2:0] {S_WAIT, S_TSREQ, S_TSWR, S_CONV, S_SCAN, S_ADCWR, S_EOE} st_t;

  st_t              st;
  logic [1:0]       src;
  logic [PW-1:0]    ts_q;
  logic [CW-1:0]    chan;
  logic [ADC_W-1:0] samp_q;

  logic above, last, want_wr;

  assign above    = adc_data > zs_thr;
  assign last     = chan == CW'(NCH - 1);
  assign want_wr  = (st == S_TSWR) || (st == S_ADCWR) || (st == S_EOE) || (st == S_SCAN && above);
  assign fifo_wr  = want_wr && !fifo_full;
  assign adc_sel  = chan;
  assign adc_req  = st == S_CONV;
  assign adc_hold = (st == S_CONV) || (st == S_SCAN) || (st == S_ADCWR);
  assign ts_req   = (st != S_TSREQ) ? 3'b000 :
                    (src == 2'd0)   ? 3'b001 :
                    (src == 2'd1)   ? 3'b010 : 3'b100;

  always_comb begin
    case (st)
      S_TSWR:  fifo_din = {3'b001, ts_q};
      S_SCAN:  fifo_din = {3'b010, chan, cyc_num};
      S_ADCWR: fifo_din = {3'b011, {(PW-ADC_W){1'b0}}, samp_q};
      S_EOE:   fifo_din = {3'b111, 11'b0, src};
      default: fifo_din = 16'h0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_WAIT;
      src      <= 2'd0;
      ts_q     <= '0;
      chan     <= '0;
      samp_q   <= '0;
      cyc_incr <= 1'b0;
    end else begin
      cyc_incr <= 1'b0;
      case (st)
        S_WAIT: if (trig_pps || trig_ext || trig_fe || trig_int) begin
          src      <= trig_pps ? 2'd0 : trig_ext ? 2'd1 : trig_fe ? 2'd2 : 2'd3;
          cyc_incr <= trig_pps;
          st       <= S_TSREQ;
        end
        S_TSREQ: if (ts_ack) begin
          ts_q <= ts_val;
          st   <= S_TSWR;
        end
        S_TSWR: if (!fifo_full) st <= S_CONV;
        S_CONV: if (adc_done) begin
          chan <= '0;
          st   <= S_SCAN;
        end
        S_SCAN:
          if (above) begin
            if (!fifo_full) begin
              samp_q <= adc_data;
              st     <= S_ADCWR;
            end
          end else if (last) st <= S_EOE;
          else chan <= chan + 1'b1;
        S_ADCWR: if (!fifo_full) begin
          if (last) st <= S_EOE;
          else begin
            chan <= chan + 1'b1;
            st   <= S_SCAN;
          end
        end
        S_EOE: if (!fifo_full) st <= S_WAIT;
        default: st <= S_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/trig_readout_seq_chk.sv
module trig_readout_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fifo_wr,
  input logic       fifo_full,
  input logic [2:0] ts_req,
  input logic       ts_ack,
  input logic       adc_req,
  input logic       adc_hold,
  input logic       adc_done,
  input logic       cyc_incr
);
  AST_NO_WR_FULL:   assert property (@(posedge clk) disable iff (!rst_n) fifo_full |-> !fifo_wr); // R9
  AST_TSREQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ts_req)); // R2
  AST_TSREQ_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) (ts_req != 3'b000 && !ts_ack) |=> $stable(ts_req)); // R4
  AST_REQ_IN_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) adc_req |-> adc_hold); // R5
  AST_REQ_WAIT:     assert property (@(posedge clk) disable iff (!rst_n) (adc_req && !adc_done) |=> adc_req); // R5
  AST_CYC_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) cyc_incr |=> !cyc_incr); // R3
  AST_ONE_EVENT:    assert property (@(posedge clk) disable iff (!rst_n) (ts_req != 3'b000) |-> !adc_hold); // R10
endmodule

bind trig_readout_seq trig_readout_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_wr(fifo_wr), .fifo_full(fifo_full),
  .ts_req(ts_req), .ts_ack(ts_ack), .adc_req(adc_req), .adc_hold(adc_hold),
  .adc_done(adc_done), .cyc_incr(cyc_incr)
);

// File: tb/tb_trig_readout_seq.sv
module tb_trig_readout_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 64;
  localparam int CW = 6;
  localparam int ADC_W = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic trig_pps = 0, trig_ext = 0, trig_fe = 0, trig_int = 0;
  logic [6:0] cyc_cnt = '0;
  logic cyc_incr;
  logic [2:0] ts_req;
  logic ts_ack = 0;
  logic [12:0] ts_val;
  logic adc_hold, adc_req, adc_done = 0;
  logic [CW-1:0] adc_sel;
  logic [ADC_W-1:0] adc_data, zs_thr = '0;
  logic fifo_wr, fifo_full = 0;
  logic [15:0] fifo_din;

  int checks = 0, errors = 0, ev_id = 0, pps_events = 0, pps_pulses = 0;
  int ts_dly = 0, adc_dly = 0;
  logic full_mode = 0;
  logic [7:0] lf = 8'hA5;
  logic [15:0] expq[$];

  function automatic logic [11:0] samp(int c, int e);
    return 12'((c * 613 + e * 1543 + c * c * e) % 4096);
  endfunction

  function automatic logic [12:0] tsv(int b, int e);
    return 13'(b * 2000 + e * 7 + 1);
  endfunction

  assign adc_data = samp(int'(adc_sel), ev_id);
  assign ts_val   = ts_req[0] ? tsv(0, ev_id) : ts_req[1] ? tsv(1, ev_id) : tsv(2, ev_id);

  trig_readout_seq dut (
    .clk(clk), .rst_n(rst_n), .trig_pps(trig_pps), .trig_ext(trig_ext), .trig_fe(trig_fe),
    .trig_int(trig_int), .cyc_num(cyc_cnt), .cyc_incr(cyc_incr), .ts_req(ts_req), .ts_ack(ts_ack),
    .ts_val(ts_val), .adc_hold(adc_hold), .adc_req(adc_req), .adc_done(adc_done),
    .adc_sel(adc_sel), .adc_data(adc_data), .zs_thr(zs_thr), .fifo_wr(fifo_wr),
    .fifo_din(fifo_din), .fifo_full(fifo_full)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // responders for the stamp and converter handshakes, and the full flag
  always @(negedge clk) begin
    lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    fifo_full <= full_mode & lf[0];
    if (ts_ack) begin ts_ack <= 0; ts_dly <= 0; end
    else if (ts_req != 3'b000) begin
      if (ts_dly == 2) ts_ack <= 1; else ts_dly <= ts_dly + 1;
    end
    if (adc_done) begin adc_done <= 0; adc_dly <= 0; end
    else if (adc_req) begin
      if (adc_dly == 3) adc_done <= 1; else adc_dly <= adc_dly + 1;
    end
  end

  // reference comparison on every clock
  initial forever begin
    @(negedge clk);
    #(CLK_PERIOD/4);
    if (rst_n) begin
      if (cyc_incr) begin cyc_cnt = cyc_cnt + 1'b1; pps_pulses++; end
      if (adc_req && !adc_hold) chk(0, "R5", "adc_req without adc_hold", 0, 1);
      if (fifo_wr) begin
        if (fifo_full) chk(0, "R9", "write while full", 1, 0);
        if (expq.size() == 0) chk(0, "R10", "unexpected word", int'(fifo_din), -1);
        else begin
          logic [15:0] e;
          e = expq.pop_front();
          case (e[15:13])
            3'b001: chk(fifo_din == e, "R4", "stamp word", int'(fifo_din), int'(e));
            3'b010: chk(fifo_din == e, "R6_R7", "channel/cycle word", int'(fifo_din), int'(e));
            3'b011: begin
              chk(fifo_din == e, "R7", "sample word", int'(fifo_din), int'(e));
              chk(adc_hold == 1'b1, "R5", "hold during scan", int'(adc_hold), 1);
            end
            default: begin
              chk(fifo_din == e, "R8", "end marker", int'(fifo_din), int'(e));
              chk(adc_hold == 1'b0, "R5", "hold released at end", int'(adc_hold), 0);
            end
          endcase
        end
      end
    end
  end

  task automatic run_event(bit p, bit x, bit f, bit i, int thr, bit full_on, bit stray);
    int src, bitidx, cyc;
    ev_id++;
    zs_thr = (thr < 0) ? samp(10, ev_id) : 12'(thr);
    src = p ? 0 : x ? 1 : f ? 2 : 3;
    bitidx = (src > 2) ? 2 : src;
    @(negedge clk);
    trig_pps = p; trig_ext = x; trig_fe = f; trig_int = i;
    full_mode = full_on;
    do @(negedge clk); while (ts_req == 3'b000);
    trig_pps = 0; trig_ext = 0; trig_fe = 0; trig_int = 0;
    chk(ts_req == 3'(1 << bitidx), "R2", "priority stamp request", int'(ts_req), 1 << bitidx);
    if (p) pps_events++;
    cyc = p ? int'(cyc_cnt) + 1 : int'(cyc_cnt);
    expq.push_back({3'b001, tsv(bitidx, ev_id)});
    for (int c = 0; c < NCH; c++) begin
      logic [11:0] s;
      s = samp(c, ev_id);
      if (s > zs_thr) begin
        expq.push_back({3'b010, 6'(c), 7'(cyc)});
        expq.push_back({3'b011, 1'b0, s});
      end
    end
    expq.push_back({3'b111, 11'b0, 2'(src)});
    if (stray) begin
      repeat (20) @(negedge clk);
      trig_ext = 1; trig_pps = 1;
      @(negedge clk);
      trig_ext = 0; trig_pps = 0;
    end
    while (expq.size() != 0) @(negedge clk);
    full_mode = 0;
    repeat (6) @(negedge clk);
    chk(ts_req == 3'b000, "R10", "no extra event after stray trigger", int'(ts_req), 0);
    chk(pps_pulses == pps_events, "R3", "cycle increments", pps_pulses, pps_events);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #(CLK_PERIOD/4);
    chk({fifo_wr, ts_req, adc_hold, adc_req, cyc_incr} == '0, "R1", "reset outputs",
        int'({fifo_wr, ts_req, adc_hold, adc_req, cyc_incr}), 0);
    run_event(1, 0, 0, 0, 2000, 0, 0);
    run_event(1, 1, 1, 1, 4095, 0, 0);
    run_event(0, 1, 1, 1, 0, 1, 0);
    run_event(0, 0, 1, 1, 1500, 0, 1);
    run_event(0, 0, 0, 1, -1, 1, 0);
    run_event(0, 1, 0, 0, 3000, 1, 1);
    run_event(1, 0, 0, 1, 800, 1, 0);
    run_event(0, 0, 1, 0, -1, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule